// File: doc/BRIEF.md
# Histogram Offset Calibration Controller

This controller removes the DC offset mismatch between the two interleaved channels (I and Q) of a 10-bit converter. It watches a stream of output codes, each tagged with the channel that produced it. Over a window of samples it counts how many codes land above the two-code midscale pair 511/512 and how many land below it. It then moves that channel's offset-correction value by a successive-approximation step and measures again. This repeats until the two counts agree within a tolerance.

The I channel is calibrated first and the Q channel second, each against its own offset value. Every new offset value goes out as a write request toward a control-register port. After the write is acknowledged, a settling window of samples is thrown away before the next measurement. The run ends with `done` when both channels are centered. It ends with `fail` when a channel stays unbalanced at the smallest step after the allowed number of adjustments. A separate input reports a full-scale range change, and the block answers it by raising a recalibration request.

Top module: `offset_cal_ctrl`

## Requirements
- R1: After reset, `wrReq`, `done`, `fail` and `recalReq` are 0, and `offsetI` and `offsetQ` are 0.
- R2: Offset values (`offsetI`, `offsetQ`, `wrData`) are sign-magnitude. Bit 12 is the sign (1 = negative) and bits 11:0 are the magnitude. Zero is written with sign 0. The value saturates at ±4095.
- R3: A measurement covers 2^WIN_LOG samples (64 by default) of the channel under calibration. A code above 512 counts as above and a code below 511 counts as below. Codes 511 and 512 count toward neither side. Samples of the other channel are ignored.
- R4: `wrReq` stays high with `wrData` and `wrChan` stable until the cycle in which `wrAck` is seen. No new write is raised before that acknowledge.
- R5: After each acknowledged write, the first SETTLE_LEN samples (8 by default) of the channel under calibration are discarded and do not enter the next measurement.
- R6: The first adjustment of a channel moves its offset by 2048. Each later adjustment uses half the previous step, never less than 1. When the above count exceeds the below count the offset decreases; otherwise it increases.
- R7: A channel is converged when the above and below counts differ by at most TOL (2 by default). The I channel (`wrChan` = 0) is calibrated first, then the Q channel (`wrChan` = 1). `done` rises after Q converges. Each channel's first write is offset 0.
- R8: If a measurement is unbalanced while the step is 1 and MAX_ITER adjustments (16 by default) have been made on that channel, `fail` is set, the run stops and `done` stays 0.
- R9: A pulse on `fsChange` sets `recalReq` and clears `done`. A `start` accepted while idle clears `recalReq`. When `start` and `fsChange` arrive in the same cycle, `recalReq` stays set.
- R10: A `start` accepted while idle resets both offsets to 0 and clears `done` and `fail` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a calibration run (taken only when idle) |
| fsChange | input | 1 | Pulse reporting a full-scale range change |
| sampleValid | input | 1 | Sample present this cycle |
| sampleChan | input | 1 | Sample channel tag, 0 = I, 1 = Q |
| sampleCode | input | 10 | Converter output code |
| wrAck | input | 1 | Acknowledge of the pending register write |
| wrReq | output | 1 | Register write request |
| wrChan | output | 1 | Channel targeted by the write |
| wrData | output | 13 | Sign-magnitude offset value to write |
| offsetI | output | 13 | Current sign-magnitude offset of channel I |
| offsetQ | output | 13 | Current sign-magnitude offset of channel Q |
| done | output | 1 | Both channels converged |
| fail | output | 1 | Calibration did not converge |
| recalReq | output | 1 | Recalibration needed after a full-scale change |

## Verification
The case where two functions can meet in one cycle is a full-scale change that arrives on the same edge as the start command. The start clears the recalibration request and the change sets it. The bench drives `start` and `fsChange` high on the same clock. It checks that `recalReq` is still set once the run has finished with `done` high, and that a later lone `start` clears it. The settle discard and the counting of the midscale codes are judged through the number of acknowledged writes per channel. A channel with no native offset must need exactly one write, even though its settle samples are deliberately corrupted.

// File: rtl/ofscal_pkg.sv
package ofscal_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WRITE,
    ST_SETTLE,
    ST_MEASURE,
    ST_DECIDE
  } calState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic initAll;   // zero offsets, select channel I, reload step
    logic winClear;  // clear sample and side counters
    logic countEn;   // count samples of the current channel
    logic measure;   // window phase (classify) instead of settle phase
    logic adjust;    // apply one step and halve it
    logic nextChan;  // move on to channel Q, reload step
  } dpStrobe_t;

endpackage

// File: rtl/ofscal_dp.sv
module ofscal_dp
  import ofscal_pkg::*;
#(
  parameter int CODE_W     = 10,
  parameter int MAG_W      = 12,
  parameter int WIN_LOG    = 6,
  parameter int SETTLE_LEN = 8,
  parameter int TOL        = 2,
  parameter int MAX_ITER   = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dpStrobe_t             strb,
  input  logic                  sampleValid,
  input  logic                  sampleChan,
  input  logic [CODE_W-1:0]     sampleCode,
  output logic                  sampLast,
  output logic                  balanced,
  output logic                  failCond,
  output logic                  curChan,
  output logic [1:0][MAG_W:0]   offSm
);

  localparam int WIN_LEN = 1 << WIN_LOG;
  localparam int SPAN    = (WIN_LEN > SETTLE_LEN) ? WIN_LEN : SETTLE_LEN;
  localparam int SCNT_W  = $clog2(SPAN + 1);
  localparam int CNT_W   = WIN_LOG + 1;
  localparam int ITER_W  = $clog2(MAX_ITER + 1);
  localparam int OFF_W   = MAG_W + 2;
  localparam int HI_CODE = 1 << (CODE_W - 1);
  localparam int LO_CODE = HI_CODE - 1;
  localparam logic signed [OFF_W-1:0] OFF_MAX = OFF_W'((1 << MAG_W) - 1);
  localparam logic [MAG_W-1:0] STEP_INIT = MAG_W'(1) << (MAG_W - 1);

  logic [SCNT_W-1:0] sampCnt;
  logic [CNT_W-1:0]  aboveCnt, belowCnt, absDiff;
  logic [MAG_W-1:0]  step;
  logic [ITER_W-1:0] iterCnt;
  logic [1:0][OFF_W-1:0] offAll;

  logic sampHit, isAbove, isBelow, goDown;
  logic [SCNT_W-1:0] winLimit;
  logic signed [OFF_W-1:0] curOff, stepExt, nextRaw, nextOff;

  assign sampHit  = sampleValid && (sampleChan == curChan);
  assign winLimit = strb.measure ? SCNT_W'(WIN_LEN - 1) : SCNT_W'(SETTLE_LEN - 1);
  assign sampLast = sampHit && (sampCnt == winLimit);
  assign isAbove  = sampleCode > CODE_W'(HI_CODE);
  assign isBelow  = sampleCode < CODE_W'(LO_CODE);

  // sample window counters, shared by settle and measure phases
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampCnt  <= '0;
      aboveCnt <= '0;
      belowCnt <= '0;
    end else if (strb.winClear || strb.initAll) begin
      sampCnt  <= '0;
      aboveCnt <= '0;
      belowCnt <= '0;
    end else if (strb.countEn && sampHit) begin
      sampCnt <= sampCnt + 1'b1;
      if (strb.measure && isAbove) aboveCnt <= aboveCnt + 1'b1;
      if (strb.measure && isBelow) belowCnt <= belowCnt + 1'b1;
    end
  end

  assign absDiff  = (aboveCnt >= belowCnt) ? aboveCnt - belowCnt : belowCnt - aboveCnt;
  assign balanced = absDiff <= CNT_W'(TOL);
  assign goDown   = aboveCnt > belowCnt;
  assign failCond = (step == MAG_W'(1)) && (iterCnt >= ITER_W'(MAX_ITER));

  // channel select, step and iteration tracking
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curChan <= 1'b0;
      step    <= STEP_INIT;
      iterCnt <= '0;
    end else if (strb.initAll || strb.nextChan) begin
      curChan <= strb.nextChan;
      step    <= STEP_INIT;
      iterCnt <= '0;
    end else if (strb.adjust) begin
      if (step > MAG_W'(1)) step <= step >> 1;
      if (iterCnt < ITER_W'(MAX_ITER)) iterCnt <= iterCnt + 1'b1;
    end
  end

  // stepped and saturated candidate for the current channel
  always_comb begin
    curOff  = $signed(offAll[curChan]);
    stepExt = $signed({{(OFF_W - MAG_W){1'b0}}, step});
    nextRaw = goDown ? curOff - stepExt : curOff + stepExt;
    if (nextRaw > OFF_MAX)       nextOff = OFF_MAX;
    else if (nextRaw < -OFF_MAX) nextOff = -OFF_MAX;
    else                         nextOff = nextRaw;
  end

  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    logic signed [OFF_W-1:0] valQ;
    logic [OFF_W-1:0]        magFull;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                  valQ <= '0;
      else if (strb.initAll)                      valQ <= '0;
      else if (strb.adjust && curChan == 1'(ch))  valQ <= nextOff;
    end

    assign offAll[ch] = valQ;
    assign magFull    = (valQ < 0) ? OFF_W'(-valQ) : OFF_W'(valQ);
    assign offSm[ch]  = {valQ < 0, magFull[MAG_W-1:0]};
  end

endmodule

// File: rtl/ofscal_ctrl.sv
module ofscal_ctrl
  import ofscal_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      fsChange,
  input  logic      wrAck,
  input  logic      sampLast,
  input  logic      balanced,
  input  logic      failCond,
  input  logic      curChan,
  output dpStrobe_t strb,
  output logic      wrReq,
  output logic      done,
  output logic      fail,
  output logic      recalReq
);

  calState_t state, stateNext;
  logic setDone, setFail, accept;

  assign accept = (state == ST_IDLE) && start;
  assign wrReq  = (state == ST_WRITE);

  always_comb begin
    stateNext = state;
    strb      = '0;
    setDone   = 1'b0;
    setFail   = 1'b0;
    unique case (state)
      ST_IDLE: if (start) begin
        strb.initAll = 1'b1;
        stateNext    = ST_WRITE;
      end
      ST_WRITE: if (wrAck) begin
        strb.winClear = 1'b1;
        stateNext     = ST_SETTLE;
      end
      ST_SETTLE: begin
        strb.countEn = 1'b1;
        if (sampLast) begin
          strb.winClear = 1'b1;
          stateNext     = ST_MEASURE;
        end
      end
      ST_MEASURE: begin
        strb.countEn = 1'b1;
        strb.measure = 1'b1;
        if (sampLast) stateNext = ST_DECIDE;
      end
      ST_DECIDE: begin
        if (balanced) begin
          if (curChan) begin
            setDone   = 1'b1;
            stateNext = ST_IDLE;
          end else begin
            strb.nextChan = 1'b1;
            stateNext     = ST_WRITE;
          end
        end else if (failCond) begin
          setFail   = 1'b1;
          stateNext = ST_IDLE;
        end else begin
          strb.adjust = 1'b1;
          stateNext   = ST_WRITE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      done     <= 1'b0;
      fail     <= 1'b0;
      recalReq <= 1'b0;
    end else begin
      state <= stateNext;
      if (fsChange || accept) done <= 1'b0;
      else if (setDone)       done <= 1'b1;
      if (accept)       fail <= 1'b0;
      else if (setFail) fail <= 1'b1;
      // a coincident full-scale change keeps the request pending
      if (fsChange)    recalReq <= 1'b1;
      else if (accept) recalReq <= 1'b0;
    end
  end

endmodule

// File: rtl/offset_cal_ctrl.sv
module offset_cal_ctrl
  import ofscal_pkg::*;
#(
  parameter int CODE_W     = 10,
  parameter int MAG_W      = 12,
  parameter int WIN_LOG    = 6,
  parameter int SETTLE_LEN = 8,
  parameter int TOL        = 2,
  parameter int MAX_ITER   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              fsChange,
  input  logic              sampleValid,
  input  logic              sampleChan,
  input  logic [CODE_W-1:0] sampleCode,
  input  logic              wrAck,
  output logic              wrReq,
  output logic              wrChan,
  output logic [MAG_W:0]    wrData,
  output logic [MAG_W:0]    offsetI,
  output logic [MAG_W:0]    offsetQ,
  output logic              done,
  output logic              fail,
  output logic              recalReq
);

  dpStrobe_t strb;
  logic sampLast, balanced, failCond, curChan;
  logic [1:0][MAG_W:0] offSm;

  ofscal_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .fsChange (fsChange),
    .wrAck    (wrAck),
    .sampLast (sampLast),
    .balanced (balanced),
    .failCond (failCond),
    .curChan  (curChan),
    .strb     (strb),
    .wrReq    (wrReq),
    .done     (done),
    .fail     (fail),
    .recalReq (recalReq)
  );

  ofscal_dp #(
    .CODE_W     (CODE_W),
    .MAG_W      (MAG_W),
    .WIN_LOG    (WIN_LOG),
    .SETTLE_LEN (SETTLE_LEN),
    .TOL        (TOL),
    .MAX_ITER   (MAX_ITER)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .sampleValid (sampleValid),
    .sampleChan  (sampleChan),
    .sampleCode  (sampleCode),
    .sampLast    (sampLast),
    .balanced    (balanced),
    .failCond    (failCond),
    .curChan     (curChan),
    .offSm       (offSm)
  );

  assign wrChan  = curChan;
  assign wrData  = offSm[curChan];
  assign offsetI = offSm[0];
  assign offsetQ = offSm[1];

endmodule

// File: rtl/offset_cal_chk.sv
module offset_cal_chk #(
  parameter int MAG_W = 12
) (
  input logic           clk,
  input logic           rstN,
  input logic           fsChange,
  input logic           wrReq,
  input logic           wrAck,
  input logic           wrChan,
  input logic [MAG_W:0] wrData,
  input logic [MAG_W:0] offsetI,
  input logic [MAG_W:0] offsetQ,
  input logic           done,
  input logic           recalReq
);

  logic lastAckChan;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                lastAckChan <= 1'b0;
    else if (wrReq && wrAck)  lastAckChan <= wrChan;
  end

  // R4
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrReq && !wrAck |=> wrReq && $stable(wrData) && $stable(wrChan));

  // R9
  recal_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    fsChange |=> recalReq && !done);

  // R2
  sign_mag_i_chk: assert property (@(posedge clk) disable iff (!rstN)
    offsetI[MAG_W] |-> offsetI[MAG_W-1:0] != '0);

  // R2
  sign_mag_q_chk: assert property (@(posedge clk) disable iff (!rstN)
    offsetQ[MAG_W] |-> offsetQ[MAG_W-1:0] != '0);

  // R7
  done_after_q_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> lastAckChan);

endmodule

bind offset_cal_ctrl offset_cal_chk #(.MAG_W(MAG_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .fsChange (fsChange),
  .wrReq    (wrReq),
  .wrAck    (wrAck),
  .wrChan   (wrChan),
  .wrData   (wrData),
  .offsetI  (offsetI),
  .offsetQ  (offsetQ),
  .done     (done),
  .recalReq (recalReq)
);

// File: tb/test_offset_cal_ctrl.sv
module test_offset_cal_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int SETTLE_LEN = 8;
  localparam int MAX_ITER   = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0, fsChange = 1'b0;
  logic sampleValid, sampleChan, wrAck;
  logic [9:0] sampleCode;
  logic wrReq, wrChan, done, fail, recalReq;
  logic [12:0] wrData, offsetI, offsetQ;

  int ran = 0, failed = 0;

  // plant state
  bit plantOn = 1'b0;
  int native [2];
  int applied [2];
  int garbage [2];
  int skewEvery [2];
  int skewCnt [2];
  int phase [2];
  int ackCount [2];
  int ackHist [2][64];
  int ackDelay = 0, waitCnt = 0;
  int ackChanL = 0, ackVal = 0;
  int holdViol = 0;
  bit prevPending = 1'b0;
  logic [12:0] prevData;
  bit chTog = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  offset_cal_ctrl i_offset_cal_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .fsChange(fsChange),
    .sampleValid(sampleValid), .sampleChan(sampleChan), .sampleCode(sampleCode),
    .wrAck(wrAck), .wrReq(wrReq), .wrChan(wrChan), .wrData(wrData),
    .offsetI(offsetI), .offsetQ(offsetQ), .done(done), .fail(fail), .recalReq(recalReq)
  );

  function automatic int smToInt(input logic [12:0] v);
    return v[12] ? -int'(v[11:0]) : int'(v[11:0]);
  endfunction

  function automatic int effOff(input int ch);
    return native[ch] + (applied[ch] >>> 2);
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    ran++;
    if (act != exp) begin
      failed++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // converter and register-port model, driven away from the active edge
  initial begin
    wrAck = 1'b0; sampleValid = 1'b0; sampleChan = 1'b0; sampleCode = '0;
    forever begin
      @(negedge clk);
      if (!plantOn) begin
        sampleValid = 1'b0; wrAck = 1'b0; prevPending = 1'b0;
        continue;
      end
      if (prevPending && (!wrReq || wrData != prevData)) holdViol++;
      if (wrAck) begin
        wrAck = 1'b0;
        applied[ackChanL] = ackVal;
        garbage[ackChanL] = SETTLE_LEN;
        if (ackCount[ackChanL] < 64) ackHist[ackChanL][ackCount[ackChanL]] = ackVal;
        ackCount[ackChanL]++;
        waitCnt = ackDelay;
      end else if (wrReq) begin
        if (waitCnt == 0) begin
          wrAck = 1'b1; ackChanL = int'(wrChan); ackVal = smToInt(wrData);
        end else waitCnt--;
      end
      prevPending = wrReq && !wrAck;
      prevData = wrData;
      begin
        int ch, code;
        ch = int'(chTog);
        chTog = ~chTog;
        if (garbage[ch] > 0) begin
          code = 0;
          garbage[ch]--;
        end else begin
          code = 511 + phase[ch] + effOff(ch);
          phase[ch] = 1 - phase[ch];
          if (skewEvery[ch] > 0) begin
            skewCnt[ch]++;
            if (skewCnt[ch] == skewEvery[ch]) begin
              skewCnt[ch] = 0;
              code = 600;
            end
          end
        end
        if (code < 0) code = 0;
        if (code > 1023) code = 1023;
        sampleValid = 1'b1;
        sampleChan = ch[0];
        sampleCode = code[9:0];
      end
    end
  end

  task automatic setupPlant(input int nI, input int nQ, input int dly, input int skQ);
    for (int c = 0; c < 2; c++) begin
      applied[c] = 0; garbage[c] = 0; skewCnt[c] = 0; phase[c] = 0;
      ackCount[c] = 0; skewEvery[c] = 0;
    end
    native[0] = nI; native[1] = nQ; skewEvery[1] = skQ;
    ackDelay = dly; waitCnt = dly; holdViol = 0;
    plantOn = 1'b1;
  endtask

  task automatic pulseStart(input bit withFs);
    @(negedge clk);
    start = 1'b1; fsChange = withFs;
    @(negedge clk);
    start = 1'b0; fsChange = 1'b0;
  endtask

  task automatic waitEnd(input string req);
    int n;
    n = 0;
    while (!(done || fail) && n < 40000) begin
      @(negedge clk);
      n++;
    end
    check(req, "run finished before timeout", int'(done || fail), 1);
  endtask

  task automatic testReset();
    check("R1", "wrReq after reset", int'(wrReq), 0);
    check("R1", "done after reset", int'(done), 0);
    check("R1", "fail after reset", int'(fail), 0);
    check("R1", "recalReq after reset", int'(recalReq), 0);
    check("R1", "offsetI after reset", int'(offsetI), 0);
    check("R1", "offsetQ after reset", int'(offsetQ), 0);
  endtask

  // no native offset: midscale codes neutral, settle garbage discarded, skew within tolerance
  task automatic testCentered();
    setupPlant(0, 0, 0, 32);
    pulseStart(1'b0);
    waitEnd("R7");
    check("R7", "done centered", int'(done), 1);
    check("R3", "I writes with codes at 511/512 only", ackCount[0], 1);
    check("R5", "Q writes with corrupted settle samples", ackCount[1], 1);
    check("R7", "Q converges inside tolerance", int'(offsetQ), 0);
    check("R7", "first I write is zero", ackHist[0][0], 0);
  endtask

  // channels with different native offsets, delayed acknowledge
  task automatic testIndependent();
    setupPlant(37, -20, 3, 0);
    pulseStart(1'b0);
    waitEnd("R7");
    check("R7", "done independent", int'(done), 1);
    check("R3", "I centered", effOff(0), 0);
    check("R3", "Q centered", effOff(1), 0);
    check("R6", "final offsetI", smToInt(offsetI), -148);
    check("R6", "final offsetQ", smToInt(offsetQ), 80);
    check("R2", "offsetI sign-magnitude code", int'(offsetI), 13'h1000 | 148);
    check("R6", "first I step", ackHist[0][1], -2048);
    check("R6", "second I step halves", ackHist[0][2], -1024);
    check("R6", "fourth I write", ackHist[0][4], -256);
    check("R6", "first Q step upward", ackHist[1][1], 2048);
    check("R4", "write held until acknowledge", holdViol, 0);
  endtask

  // offset cannot be compensated: saturation then failure
  task automatic testFail();
    setupPlant(1500, 0, 1, 0);
    pulseStart(1'b0);
    waitEnd("R8");
    check("R8", "fail set", int'(fail), 1);
    check("R8", "done stays low", int'(done), 0);
    check("R8", "I write count", ackCount[0], MAX_ITER + 1);
    check("R8", "Q never written", ackCount[1], 0);
    check("R2", "offsetI saturated code", int'(offsetI), 13'h1FFF);
  endtask

  task automatic testRestart();
    setupPlant(0, 0, 0, 0);
    pulseStart(1'b0);
    check("R10", "fail cleared on start", int'(fail), 0);
    check("R10", "offsetI zeroed on start", int'(offsetI), 0);
    waitEnd("R10");
    check("R10", "done after restart", int'(done), 1);
  endtask

  task automatic testRecal();
    @(negedge clk);
    fsChange = 1'b1;
    @(negedge clk);
    fsChange = 1'b0;
    check("R9", "recalReq set by change", int'(recalReq), 1);
    check("R9", "done cleared by change", int'(done), 0);
    setupPlant(0, 0, 0, 0);
    pulseStart(1'b1);
    check("R9", "recalReq kept on coincident start", int'(recalReq), 1);
    waitEnd("R9");
    check("R9", "done after coincident run", int'(done), 1);
    check("R9", "recalReq still set after run", int'(recalReq), 1);
    pulseStart(1'b0);
    check("R9", "recalReq cleared by start", int'(recalReq), 0);
    waitEnd("R9");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testCentered();
    testIndependent();
    testFail();
    testRestart();
    testRecal();
    $display("  [TB] %0d tests run, %0d failed", ran, failed);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    ran++;
    failed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", ran, failed);
    $finish;
  end

endmodule